// File: doc/BRIEF.md
# Addressed Serial Word Receiver

This block is the digital front end of a four-channel converter. A host writes to it over three wires: a serial clock, a data line and an active-low select. Everything runs on a faster system clock. The three pins are synchronised into that domain, and their edges are detected there. Data bits are shifted in on rising serial-clock edges while the select is low. The block keeps only the most recent word's worth of bits.

When the select goes high, the block splits the retained word into a two-bit channel address and a data field. It then issues a single-cycle, one-hot write strobe, with the data, to the input register of the addressed channel. A serial output taps the shift path a fixed number of edges behind the input, so several of these blocks can be chained on one bus.

The parameter `DATA_W` sets the data field: 16 by default, or 14 for the narrower variant. The word length is `DATA_W + 2`.

Top module: `serial_word_rx`

## Requirements
- R1: On each rising `sclk` edge seen while `cs_n` is low, the `sdi` level is shifted into the shift register, MSB first. The retained word is the last `DATA_W+2` bits. Its two most significant bits are the channel address, and the remaining `DATA_W` bits are the data field.
- R2: While `cs_n` is high, `sclk` and `sdi` activity has no effect. The retained word and `sdo` keep their values, and no strobe is issued.
- R3: When `cs_n` rises, the retained word is committed. If the frame had more clocks than the word length, the earliest extra bits are discarded. For example, a 24-clock frame whose last 18 bits are address and data commits those 18 bits.
- R4: The address selects the strobe line: 00 raises `wr_stb[0]`, 01 raises `wr_stb[1]`, 10 raises `wr_stb[2]` and 11 raises `wr_stb[3]`. No other line rises. `wr_data` carries the committed data field.
- R5: Each rising edge of `cs_n` produces exactly one strobe, exactly one system-clock cycle wide. It is first visible after the third rising system-clock edge following the `cs_n` rise, because two synchroniser stages and one output register lie on the path.
- R6: `sdo` is a delayed copy of the serial input. The bit captured on serial edge n appears on `sdo` after serial edge n+`DATA_W`+2. That is a latency of 19 edges for the 16-bit field and 17 edges for the 14-bit field, counting the capturing edge. Before any such bit exists, `sdo` shows zero.
- R7: A frame with fewer clocks than the word length still commits. The committed word is the low bits of the shift register, and it includes bits left over from earlier frames.
- R8: An active-low `rst_n` clears the shift register, `sdo`, `wr_stb` and `wr_data` to zero. After reset, a commit with no clocks yields address 0 and data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| cs_n | input | 1 | Active-low frame select; its rising edge commits the word |
| wr_stb | output | 4 | One-hot, one-cycle write strobe per channel |
| wr_data | output | DATA_W | Data field for the strobed channel |
| sdo | output | 1 | Delayed serial output for daisy chaining |

## Verification
The bench sends frames of 24 and 20 clocks with the padding bits set to one. A design that kept the earliest bits instead of the latest would commit a corrupted address and data. It also sends frames of 5 and 1 clocks, whose committed word mixes fresh bits with residue from earlier frames. A design that cleared the register at the start of a frame, or that ignored short frames, would show up there.

The bench toggles `sclk` while `cs_n` is high, then commits an empty frame. Any leak into the register appears in the committed word or on `sdo`. Strobe latency and width are measured in system cycles, so a strobe that fires twice, lasts two cycles, or fires on the falling edge of `cs_n` is reported.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int ADDR_W = 2;
  localparam int NUM_CH = 1 << ADDR_W;

  // Address = top ADDR_W bits of a word of length ww (right-justified in w).
  function automatic logic [ADDR_W-1:0] word_addr(input logic [31:0] w, input int ww);
    logic [31:0] t;
    t = w >> (ww - ADDR_W);
    return t[ADDR_W-1:0];
  endfunction

  // Data = bits below the address field.
  function automatic logic [31:0] word_data(input logic [31:0] w, input int ww);
    return w & ((32'd1 << (ww - ADDR_W)) - 32'd1);
  endfunction

  function automatic logic [NUM_CH-1:0] addr_onehot(input logic [ADDR_W-1:0] a);
    logic [NUM_CH-1:0] r;
    r    = '0;
    r[a] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic st1, st2, st3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= RST_VAL[i];
        st2 <= RST_VAL[i];
        st3 <= RST_VAL[i];
      end else begin
        st1 <= d[i];
        st2 <= st1;
        st3 <= st2;
      end
    end
    assign q[i]      = st2;
    assign q_prev[i] = st3;
  end
endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] chain
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  chain <= '0;
    else if (en) chain <= {chain[W-2:0], din};
  end
endmodule

// File: rtl/srx_commit.sv
module srx_commit
  import srx_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int WORD_W = DATA_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [WORD_W-1:0] word,
  output logic [NUM_CH-1:0] wr_stb,
  output logic [DATA_W-1:0] wr_data
);
  logic [31:0]       word_ext;
  logic [31:0]       data_ext;
  logic [ADDR_W-1:0] addr;

  assign word_ext = 32'(word);
  assign addr     = word_addr(word_ext, WORD_W);
  assign data_ext = word_data(word_ext, WORD_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= '0;
      wr_data <= '0;
    end else if (go) begin
      wr_stb  <= addr_onehot(addr);
      wr_data <= data_ext[DATA_W-1:0];
    end else begin
      wr_stb  <= '0;
    end
  end
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
  import srx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              cs_n,
  output logic [3:0]        wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo
);
  localparam int WORD_W  = DATA_W + ADDR_W;
  localparam int CHAIN_W = WORD_W + 1;

  logic [2:0]         sync_q, sync_prev;
  logic               sclk_rise, cs_rise, cs_lo_s, sdi_s, shift_en;
  logic [CHAIN_W-1:0] chain;

  // bit 2 = cs_n (idles high), bit 1 = sdi, bit 0 = sclk
  srx_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sdi, sclk}),
    .q(sync_q), .q_prev(sync_prev)
  );

  assign sclk_rise = sync_q[0] & ~sync_prev[0];
  assign cs_rise   = sync_q[2] & ~sync_prev[2];
  assign cs_lo_s   = ~sync_q[2];
  assign sdi_s     = sync_q[1];
  assign shift_en  = sclk_rise & cs_lo_s;

  // Low WORD_W bits form the word; the extra top stage is the daisy-chain tap.
  srx_shift #(.W(CHAIN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(shift_en), .din(sdi_s), .chain(chain)
  );

  srx_commit #(.DATA_W(DATA_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .go(cs_rise), .word(chain[WORD_W-1:0]),
    .wr_stb(wr_stb), .wr_data(wr_data)
  );

  assign sdo = chain[WORD_W];
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DATA_W = 16,
  localparam int WORD_W = DATA_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_rise,
  input logic              cs_rise,
  input logic              cs_lo_s,
  input logic              sdi_s,
  input logic [WORD_W:0]   chain,
  input logic [3:0]        wr_stb,
  input logic [DATA_W-1:0] wr_data,
  input logic              sdo
);
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && cs_lo_s) |=> chain[0] == $past(sdi_s)); // R1
  AST_HOLD_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_lo_s |=> $stable(chain)); // R2
  AST_COMMIT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> wr_data == $past(chain[DATA_W-1:0])); // R3
  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb)); // R4
  AST_STB_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> $countones(wr_stb) == 1); // R5
  AST_STB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_stb) |-> $past(cs_rise)); // R5
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_stb) |=> !(|wr_stb)); // R5
  AST_SDO_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && cs_lo_s) |=> sdo == $past(chain[WORD_W-1])); // R6
endmodule

bind serial_word_rx srx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .cs_rise(cs_rise),
  .cs_lo_s(cs_lo_s), .sdi_s(sdi_s), .chain(chain), .wr_stb(wr_stb),
  .wr_data(wr_data), .sdo(sdo)
);

// File: tb/serial_word_rx_tb.sv
module serial_word_rx_tb;
  localparam int DATA_W = 16;
  localparam int WORD_W = DATA_W + 2;
  localparam int HALF   = 4;   // system cycles per serial half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1;
  logic [3:0]        wr_stb;
  logic [DATA_W-1:0] wr_data;
  logic              sdo;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [WORD_W:0] mchain = '0;   // bench model of shifted history

  always #2 clk = ~clk;           // 250 MHz

  serial_word_rx #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
    .wr_stb(wr_stb), .wr_data(wr_data), .sdo(sdo)
  );

  // {nbits[7:0], addr[1:0], data[15:0]}; padding beyond 18 bits is all ones
  localparam logic [25:0] VEC [9] = '{
    {8'd18, 2'd0, 16'h1234},
    {8'd18, 2'd1, 16'hBEEF},
    {8'd24, 2'd2, 16'h0F0F},
    {8'd18, 2'd3, 16'hFFFF},
    {8'd24, 2'd1, 16'h8000},
    {8'd5,  2'd2, 16'h0013},
    {8'd18, 2'd2, 16'h0000},
    {8'd20, 2'd0, 16'hA5A5},
    {8'd1,  2'd3, 16'h0001}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic ser_bit(input logic b);
    @(negedge clk); sdi = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    if (!cs_n) mchain = {mchain[WORD_W-1:0], b};
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_frame(input logic [23:0] bits, input int n);
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) ser_bit(bits[i]);
    repeat (HALF) @(negedge clk);
  endtask

  // raise cs_n and measure the strobe
  task automatic commit_check(input logic [1:0] ea, input logic [15:0] ed, input string tag);
    int first = 0, width = 0;
    logic [3:0]  stb = '0;
    logic [15:0] dat = '0;
    @(negedge clk); cs_n = 1'b1;
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      if (|wr_stb) begin
        if (first == 0) begin first = n; stb = wr_stb; dat = wr_data; end
        width++;
      end
    end
    chk(first == 3, {tag, " R5 latency"}, first, 3);
    chk(width == 1, {tag, " R5 width"}, width, 1);
    chk(stb == (4'b1 << ea), {tag, " R4 strobe"}, int'(stb), int'(4'b1 << ea));
    chk(dat == ed, {tag, " data"}, int'(dat), int'(ed));
    chk(sdo == mchain[WORD_W], {tag, " R6 sdo"}, int'(sdo), int'(mchain[WORD_W]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R8 reset state
    chk(wr_stb == 4'b0, "R8 strobe in reset", int'(wr_stb), 0);
    chk(wr_data == '0, "R8 data in reset", int'(wr_data), 0);
    chk(sdo == 1'b0, "R8 sdo in reset", int'(sdo), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R1, R3, R4, R7
    for (int k = 0; k < 9; k++) begin
      logic [7:0]  nb;
      logic [1:0]  a;
      logic [15:0] d;
      logic [1:0]  ea;
      logic [15:0] ed;
      nb = VEC[k][25:18];
      a  = VEC[k][17:16];
      d  = VEC[k][15:0];
      send_frame({6'h3F, a, d}, int'(nb));
      if (nb >= 8'(WORD_W)) begin ea = a; ed = d; end   // R1/R3: last 18 bits
      else begin ea = mchain[17:16]; ed = mchain[15:0]; end // R7: residue kept
      chk(mchain[17:0] == {ea, ed}, "R1 model word", int'(mchain[17:0]), int'({ea, ed}));
      commit_check(ea, ed, (nb < 8'(WORD_W)) ? "R7 short frame" :
                           (nb > 8'(WORD_W)) ? "R3 long frame" : "R1 full frame");
    end

    // R2: activity with cs_n high is ignored
    begin
      logic sdo_before;
      int stray = 0;
      sdo_before = sdo;
      for (int t = 0; t < 6; t++) begin
        @(negedge clk); sdi = t[0];
        repeat (HALF) @(negedge clk); sclk = 1'b1;
        for (int j = 0; j < HALF; j++) begin @(negedge clk); if (|wr_stb) stray++; end
        sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      chk(stray == 0, "R2 no strobe while deselected", stray, 0);
      chk(sdo == sdo_before, "R2 sdo held", int'(sdo), int'(sdo_before));
      send_frame(24'h0, 0);
      commit_check(mchain[17:16], mchain[15:0], "R2 held word");
    end

    // R8: mid-run reset clears everything
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(wr_data == '0, "R8 data cleared", int'(wr_data), 0);
    chk(sdo == 1'b0, "R8 sdo cleared", int'(sdo), 0);
    rst_n = 1'b1;
    mchain = '0;
    repeat (4) @(negedge clk);
    send_frame(24'h0, 0);
    commit_check(2'd0, 16'h0000, "R8 empty after reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule